// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This controller sits beside the datapath of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Source registers are read in decode and results are written back in writeback. An instruction that needs a result from one of the two instructions just ahead of it would otherwise read a stale value. The controller compares the execute-stage source specifiers against the destinations of the memory and writeback stages. It then steers each execute operand multiplexer to the newest copy of the value.

An ALU result can be bypassed, but load data exists only once the memory stage ends. A consumer that directly follows a load therefore cannot be served by a bypass. The controller spots this pair while the consumer is still in decode. For one cycle it drops the fetch and decode enables and asks the pipeline to put a no-op into execute. On the next cycle the load has reached writeback, and its value is bypassed from there.

The block is purely combinational. Every output is a function of the current stage contents.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each operand select uses the encoding 2'b00 = register file, 2'b01 = writeback result, 2'b10 = memory-stage result. It is 2'b00 whenever no qualifying producer matches, and never 2'b11.
- R2: An operand select is 2'b10 when the memory stage is valid, writes a register, and its destination equals that execute source (nonzero).
- R3: An operand select is 2'b01 when the writeback stage is valid, writes a register, and its destination equals that execute source (nonzero), with no memory-stage match.
- R4: When both the memory and writeback stages match the same source, the memory stage wins and the select is 2'b10.
- R5: Register 0 is never bypassed (select 2'b00) and never causes a stall.
- R6: A stage with its valid bit or its write enable low never qualifies as a bypass source or as a stalling load.
- R7: When execute holds a valid, register-writing load whose nonzero destination equals either decode source, fetch_en and decode_en are 0 and ex_bubble is 1.
- R8: With no load-use pair (for example, a non-load producer in execute), fetch_en and decode_en are 1 and ex_bubble is 0.
- R9: fetch_en and decode_en are always equal, and ex_bubble is always their inverse.
- R10: In the cycle after a load-use stall, the load sits in writeback and the memory stage holds the bubble. The consumer's operand then selects 2'b01.
- R11: The two operand selects are resolved independently, so they may differ in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs_a | input | REG_W | First source specifier of the decode instruction |
| dec_rs_b | input | REG_W | Second source specifier of the decode instruction |
| ex_rs_a | input | REG_W | First source specifier of the execute instruction |
| ex_rs_b | input | REG_W | Second source specifier of the execute instruction |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_rd | input | REG_W | Execute destination specifier |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_rd | input | REG_W | Memory destination specifier |
| wb_valid | input | 1 | Writeback stage holds a real instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| wb_rd | input | REG_W | Writeback destination specifier |
| fwd_sel_a | output | 2 | Execute operand A multiplexer select |
| fwd_sel_b | output | 2 | Execute operand B multiplexer select |
| fetch_en | output | 1 | Fetch stage advance enable (0 = hold) |
| decode_en | output | 1 | Decode stage advance enable (0 = hold) |
| ex_bubble | output | 1 | Replace the instruction entering execute with a no-op |

## Verification
The checks assume that every input is a settled, known value whenever it is sampled. They also assume that a load in the memory stage never meets a dependent instruction in execute, because the interlock has already split such pairs. The stimulus changes inputs only on the rising edge and samples on the falling edge. Register specifiers are drawn from a small set that includes register 0, so matches, double matches and zero-register cases occur often. The random load flag is only ever set on the execute stage, which keeps the stimulus inside that assumption.

// File: rtl/hfu_pkg.sv
package hfu_pkg;

  // Operand multiplexer select encoding
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/hfu_wr_match.sv
// Qualified producer/consumer comparison for one pair of specifiers.
module hfu_wr_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             vld,
  input  logic             wen,
  input  logic [REG_W-1:0] rd,
  output logic             hit
);

  logic rd_nonzero;

  always_comb begin
    rd_nonzero = |rd;
    hit        = vld && wen && rd_nonzero && (rd == src);
  end

endmodule

// File: rtl/hfu_operand_ctl.sv
// Select generation for one execute operand, newest producer first.
module hfu_operand_ctl
  import hfu_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             mem_valid,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             wb_valid,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_rd,
  output fwd_sel_e         sel
);

  logic hit_mem;
  logic hit_wb;

  hfu_wr_match #(.REG_W(REG_W)) u_mem_cmp (
    .src (src),
    .vld (mem_valid),
    .wen (mem_wen),
    .rd  (mem_rd),
    .hit (hit_mem)
  );

  hfu_wr_match #(.REG_W(REG_W)) u_wb_cmp (
    .src (src),
    .vld (wb_valid),
    .wen (wb_wen),
    .rd  (wb_rd),
    .hit (hit_wb)
  );

  always_comb begin
    if (hit_mem)     sel = FWD_MEM;
    else if (hit_wb) sel = FWD_WB;
    else             sel = FWD_RF;
  end

endmodule

// File: rtl/hfu_load_interlock.sv
// Load-use detection between the execute-stage load and the decode sources.
module hfu_load_interlock #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC*REG_W-1:0] dec_srcs,
  input  logic                     ex_valid,
  input  logic                     ex_wen,
  input  logic                     ex_is_load,
  input  logic [REG_W-1:0]         ex_rd,
  output logic                     stall
);

  logic             load_vld;
  logic [NUM_SRC-1:0] src_hit;

  always_comb load_vld = ex_valid && ex_is_load;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    hfu_wr_match #(.REG_W(REG_W)) u_cmp (
      .src (dec_srcs[i*REG_W +: REG_W]),
      .vld (load_vld),
      .wen (ex_wen),
      .rd  (ex_rd),
      .hit (src_hit[i])
    );
  end

  always_comb stall = |src_hit;

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hfu_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] dec_rs_a,
  input  logic [REG_W-1:0] dec_rs_b,
  input  logic [REG_W-1:0] ex_rs_a,
  input  logic [REG_W-1:0] ex_rs_b,
  input  logic             ex_valid,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             mem_valid,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             wb_valid,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_rd,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b,
  output logic             fetch_en,
  output logic             decode_en,
  output logic             ex_bubble
);

  localparam int unsigned NUM_SRC = 2;

  logic [NUM_SRC*REG_W-1:0] ex_srcs;
  logic [NUM_SRC*REG_W-1:0] dec_srcs;
  fwd_sel_e                 op_sel [NUM_SRC];
  logic                     load_use;

  always_comb begin
    ex_srcs  = {ex_rs_b, ex_rs_a};
    dec_srcs = {dec_rs_b, dec_rs_a};
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_op
    hfu_operand_ctl #(.REG_W(REG_W)) u_op_ctl (
      .src       (ex_srcs[i*REG_W +: REG_W]),
      .mem_valid (mem_valid),
      .mem_wen   (mem_wen),
      .mem_rd    (mem_rd),
      .wb_valid  (wb_valid),
      .wb_wen    (wb_wen),
      .wb_rd     (wb_rd),
      .sel       (op_sel[i])
    );
  end

  hfu_load_interlock #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_interlock (
    .dec_srcs   (dec_srcs),
    .ex_valid   (ex_valid),
    .ex_wen     (ex_wen),
    .ex_is_load (ex_is_load),
    .ex_rd      (ex_rd),
    .stall      (load_use)
  );

  always_comb begin
    fwd_sel_a = op_sel[0];
    fwd_sel_b = op_sel[1];
    fetch_en  = !load_use;
    decode_en = !load_use;
    ex_bubble = load_use;
  end

endmodule

// File: rtl/hfu_checker.sv
module hfu_checker #(
  parameter int unsigned REG_W = 5
) (
  input logic [REG_W-1:0] dec_rs_a,
  input logic [REG_W-1:0] dec_rs_b,
  input logic [REG_W-1:0] ex_rs_a,
  input logic [REG_W-1:0] ex_rs_b,
  input logic             ex_valid,
  input logic             ex_wen,
  input logic             ex_is_load,
  input logic [REG_W-1:0] ex_rd,
  input logic             mem_valid,
  input logic             mem_wen,
  input logic [REG_W-1:0] mem_rd,
  input logic             wb_valid,
  input logic             wb_wen,
  input logic [REG_W-1:0] wb_rd,
  input logic [1:0]       fwd_sel_a,
  input logic [1:0]       fwd_sel_b,
  input logic             fetch_en,
  input logic             decode_en,
  input logic             ex_bubble
);

  logic mem_live, wb_live, ld_live;

  always_comb begin
    mem_live = mem_valid && mem_wen && (mem_rd != '0);
    wb_live  = wb_valid && wb_wen && (wb_rd != '0);
    ld_live  = ex_valid && ex_wen && ex_is_load && (ex_rd != '0);

    // R1
    legal_sel_chk: assert (fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11)
      else $error("select uses reserved code");

    // R4
    mem_prio_chk: assert (!(mem_live && mem_rd == ex_rs_a) || fwd_sel_a == 2'b10)
      else $error("memory stage lost priority on operand A");

    // R5
    zero_src_chk: assert ((ex_rs_a != '0 || fwd_sel_a == 2'b00) &&
                          (ex_rs_b != '0 || fwd_sel_b == 2'b00))
      else $error("register 0 was bypassed");

    // R6
    dead_stage_chk: assert (mem_live || wb_live ||
                            (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00))
      else $error("bypass from a non-qualifying stage");

    // R7
    load_use_chk: assert (!(ld_live && (ex_rd == dec_rs_a || ex_rd == dec_rs_b)) ||
                          ex_bubble)
      else $error("load-use pair not stalled");

    // R9
    stall_coherent_chk: assert (fetch_en == decode_en && ex_bubble == !fetch_en)
      else $error("stall enables disagree");
  end

endmodule

bind hazard_fwd_unit hfu_checker #(.REG_W(REG_W)) u_hfu_checker (
  .dec_rs_a   (dec_rs_a),
  .dec_rs_b   (dec_rs_b),
  .ex_rs_a    (ex_rs_a),
  .ex_rs_b    (ex_rs_b),
  .ex_valid   (ex_valid),
  .ex_wen     (ex_wen),
  .ex_is_load (ex_is_load),
  .ex_rd      (ex_rd),
  .mem_valid  (mem_valid),
  .mem_wen    (mem_wen),
  .mem_rd     (mem_rd),
  .wb_valid   (wb_valid),
  .wb_wen     (wb_wen),
  .wb_rd      (wb_rd),
  .fwd_sel_a  (fwd_sel_a),
  .fwd_sel_b  (fwd_sel_b),
  .fetch_en   (fetch_en),
  .decode_en  (decode_en),
  .ex_bubble  (ex_bubble)
);

// File: tb/hazard_fwd_unit_bench.sv
module hazard_fwd_unit_bench;

  localparam int unsigned REG_W = 5;

  logic clk;
  logic [REG_W-1:0] dec_rs_a, dec_rs_b, ex_rs_a, ex_rs_b, ex_rd, mem_rd, wb_rd;
  logic ex_valid, ex_wen, ex_is_load, mem_valid, mem_wen, wb_valid, wb_wen;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic fetch_en, decode_en, ex_bubble;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  hazard_fwd_unit #(.REG_W(REG_W)) u_hazard_fwd_unit (
    .dec_rs_a (dec_rs_a), .dec_rs_b (dec_rs_b),
    .ex_rs_a (ex_rs_a), .ex_rs_b (ex_rs_b),
    .ex_valid (ex_valid), .ex_wen (ex_wen), .ex_is_load (ex_is_load), .ex_rd (ex_rd),
    .mem_valid (mem_valid), .mem_wen (mem_wen), .mem_rd (mem_rd),
    .wb_valid (wb_valid), .wb_wen (wb_wen), .wb_rd (wb_rd),
    .fwd_sel_a (fwd_sel_a), .fwd_sel_b (fwd_sel_b),
    .fetch_en (fetch_en), .decode_en (decode_en), .ex_bubble (ex_bubble)
  );

  function automatic logic [1:0] exp_sel(input logic [REG_W-1:0] src);
    if (src != 0 && mem_valid && mem_wen && mem_rd == src) return 2'b10;
    if (src != 0 && wb_valid && wb_wen && wb_rd == src)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic exp_stall();
    return ex_valid && ex_wen && ex_is_load && ex_rd != 0 &&
           (ex_rd == dec_rs_a || ex_rd == dec_rs_b);
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clear();
    {dec_rs_a, dec_rs_b, ex_rs_a, ex_rs_b, ex_rd, mem_rd, wb_rd} = '0;
    {ex_valid, ex_wen, ex_is_load, mem_valid, mem_wen, wb_valid, wb_wen} = '0;
  endtask

  // Check every output against the bench model at the falling edge
  task automatic check_all(input string rs, input string rst);
    @(negedge clk);
    chk({rs, " sel_a"}, fwd_sel_a, exp_sel(ex_rs_a));
    chk({rs, " sel_b"}, fwd_sel_b, exp_sel(ex_rs_b));
    chk({rst, " stall"}, {1'b0, ex_bubble}, {1'b0, exp_stall()});
    chk("R9 coherence", {fetch_en, decode_en}, {!ex_bubble, !ex_bubble});
    @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clear();
    @(posedge clk);

    // Idle state: R1, R8
    @(negedge clk);
    chk("R1 idle sel_a", fwd_sel_a, 2'b00);
    chk("R1 idle sel_b", fwd_sel_b, 2'b00);
    chk("R8 idle enables", {fetch_en, decode_en}, 2'b11);
    chk("R8 idle bubble", {1'b0, ex_bubble}, 2'b00);
    @(posedge clk);

    // R2: memory match on operand A
    clear(); ex_rs_a = 5'd9; mem_valid = 1; mem_wen = 1; mem_rd = 5'd9;
    @(negedge clk); chk("R2 mem bypass", fwd_sel_a, 2'b10); @(posedge clk);

    // R3: writeback match on operand B
    clear(); ex_rs_b = 5'd12; wb_valid = 1; wb_wen = 1; wb_rd = 5'd12;
    @(negedge clk); chk("R3 wb bypass", fwd_sel_b, 2'b01); @(posedge clk);

    // R4: both match, memory wins
    clear(); ex_rs_a = 5'd4; mem_valid = 1; mem_wen = 1; mem_rd = 5'd4;
    wb_valid = 1; wb_wen = 1; wb_rd = 5'd4;
    @(negedge clk); chk("R4 priority", fwd_sel_a, 2'b10); @(posedge clk);

    // R5: register 0 never bypassed nor stalls
    clear(); mem_valid = 1; mem_wen = 1; wb_valid = 1; wb_wen = 1;
    ex_valid = 1; ex_wen = 1; ex_is_load = 1;
    @(negedge clk);
    chk("R5 zero sel_a", fwd_sel_a, 2'b00);
    chk("R5 zero stall", {1'b0, ex_bubble}, 2'b00);
    @(posedge clk);

    // R6: invalid memory stage, non-writing writeback stage
    clear(); ex_rs_a = 5'd6; mem_rd = 5'd6; mem_wen = 1; wb_rd = 5'd6; wb_valid = 1;
    ex_rd = 5'd3; ex_is_load = 1; ex_wen = 1; dec_rs_a = 5'd3;
    @(negedge clk);
    chk("R6 dead sel_a", fwd_sel_a, 2'b00);
    chk("R6 invalid load", {1'b0, ex_bubble}, 2'b00);
    @(posedge clk);

    // R7: load-use on decode operand B
    clear(); ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_rd = 5'd7; dec_rs_b = 5'd7;
    @(negedge clk);
    chk("R7 stall enables", {fetch_en, decode_en}, 2'b00);
    chk("R7 bubble", {1'b0, ex_bubble}, 2'b01);
    @(posedge clk);

    // R10: next cycle, load in writeback, bubble in memory
    clear(); wb_valid = 1; wb_wen = 1; wb_rd = 5'd7; ex_rs_b = 5'd7; ex_valid = 1;
    @(negedge clk);
    chk("R10 post-stall sel_b", fwd_sel_b, 2'b01);
    chk("R10 no restall", {1'b0, ex_bubble}, 2'b00);
    @(posedge clk);

    // R8: ALU producer in execute never stalls
    clear(); ex_valid = 1; ex_wen = 1; ex_rd = 5'd7; dec_rs_a = 5'd7;
    @(negedge clk); chk("R8 alu no stall", {fetch_en, decode_en}, 2'b11); @(posedge clk);

    // R11: operands resolved independently
    clear(); ex_rs_a = 5'd2; ex_rs_b = 5'd3;
    mem_valid = 1; mem_wen = 1; mem_rd = 5'd2; wb_valid = 1; wb_wen = 1; wb_rd = 5'd3;
    @(negedge clk);
    chk("R11 sel_a", fwd_sel_a, 2'b10);
    chk("R11 sel_b", fwd_sel_b, 2'b01);
    @(posedge clk);

    // Constrained random: small specifier range gives frequent matches
    for (int n = 0; n < 3000; n++) begin
      dec_rs_a   = REG_W'($urandom % 4);
      dec_rs_b   = REG_W'($urandom % 4);
      ex_rs_a    = REG_W'($urandom % 4);
      ex_rs_b    = REG_W'($urandom % 4);
      ex_rd      = REG_W'($urandom % 4);
      mem_rd     = REG_W'($urandom % 4);
      wb_rd      = REG_W'($urandom % 4);
      ex_valid   = 1'($urandom);
      ex_wen     = 1'($urandom);
      ex_is_load = 1'($urandom);
      mem_valid  = 1'($urandom);
      mem_wen    = 1'($urandom);
      wb_valid   = 1'($urandom);
      wb_wen     = 1'($urandom);
      check_all("R11 rand", "R7 rand");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule